// File: doc/BRIEF.md
# Tagged Sample Buffer with Threshold Interrupt

This block holds up to 512 conversion results, each a 16-bit sample paired with a 5-bit channel tag. It sits between an acquisition sequencer and a host register port. The sequencer pushes a sample and its tag together. It watches `full` and stops producing while it is high. A flush strobe discards everything held in the buffer.

The host reads through four read strobes and one write strobe. The word strobe returns the whole head sample and removes it. The low-byte strobe returns the lower half and leaves the entry in place. The high-byte strobe returns the upper half and removes the entry, so a byte-wide host reads low then high. The status strobe returns a status word with three fields: the live occupancy, the channel tag of the head entry and the interrupt enable. A write to the status address sets the interrupt level and the enable. The interrupt is level sensitive. It stays high while the enable is set and occupancy is above the level.

All read results appear on `host_rdata` one clock after the strobe. `host_rdata` keeps its last value until the next read that has something to return. The reset input is asynchronous and active low. It is released through a two-flop synchronizer.

Top module: `tagq_top`

## Requirements
- R1: After reset the buffer is empty and `full` is low. `host_rdata` is 0, the interrupt enable is 0, the interrupt level is 256 and `irq` is low.
- R2: A push while not full stores the sample and tag at the tail. `full` is high exactly when 512 entries are held. A push while full, with no pop in the same cycle, is ignored.
- R3: A word read of a non-empty buffer puts the head sample on `host_rdata` on the next cycle and removes the entry. Entries leave in the order they were pushed. If several read strobes are high together, the priority is word, then high byte, then low byte, then status.
- R4: A low-byte read puts {8'h00, head[7:0]} on `host_rdata` and keeps the entry. A high-byte read puts {8'h00, head[15:8]} on `host_rdata` and removes the entry.
- R5: A status read returns a 16-bit word. Bits 15:6 hold the occupancy. Bits 5:1 hold the head entry's tag, or 0 when the buffer is empty. Bit 0 holds the interrupt enable. The read changes no state.
- R6: A status write loads the interrupt level from `host_wdata[15:6]` and the enable from `host_wdata[0]`.
- R7: `irq` is high exactly when the enable is 1 and the occupancy is strictly greater than the level.
- R8: A flush empties the buffer, and the occupancy is 0 on the next cycle. A flush wins over a push or a pop in the same cycle, and neither of them takes effect.
- R9: A word or byte read of an empty buffer leaves `host_rdata` and the occupancy unchanged.
- R10: A push and a pop accepted in the same cycle leave the occupancy unchanged. This also holds when the buffer is full, where the pop frees the slot that the push fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_en | input | 1 | Push strobe from the sequencer |
| push_sample | input | 16 | Sample to store |
| push_chan | input | 5 | Channel tag of the sample |
| flush | input | 1 | Empty the buffer |
| full | output | 1 | Buffer holds 512 entries |
| rd_word | input | 1 | Read full sample and pop |
| rd_lo | input | 1 | Read low byte, no pop |
| rd_hi | input | 1 | Read high byte and pop |
| rd_stat | input | 1 | Read status word |
| wr_stat | input | 1 | Write interrupt level and enable |
| host_wdata | input | 16 | Write data for the status write |
| host_rdata | output | 16 | Registered read result |
| irq | output | 1 | Active-high threshold interrupt |

## Verification
Several pairs of operations can fall in the same cycle, and the bench provokes each pair. A sequencer push can meet a host pop. A flush can meet a push or a pop. A status write can meet a status read.

The bench forces these cases directly. It pushes and pops at the full and empty boundaries. It raises flush together with a push and a word read. It also draws all strobes independently from a seeded random stream, so they collide in arbitrary combinations.

Each collision is judged against a queue model in the bench. The model applies pop before push, drops both when a flush is present, and computes every read result from the state before the clock edge. Occupancy, `full`, `irq` and `host_rdata` are then compared with the model after every edge.

// File: rtl/tagq_pkg.sv
package tagq_pkg;
  typedef enum logic [2:0] {
    RSEL_NONE = 3'd0,
    RSEL_WORD = 3'd1,
    RSEL_HI   = 3'd2,
    RSEL_LO   = 3'd3,
    RSEL_STAT = 3'd4
  } rsel_e;

  function automatic rsel_e pick_read(input logic w, input logic h,
                                      input logic l, input logic s);
    if (w)      return RSEL_WORD;
    else if (h) return RSEL_HI;
    else if (l) return RSEL_LO;
    else if (s) return RSEL_STAT;
    else        return RSEL_NONE;
  endfunction
endpackage

// File: rtl/tagq_ptrs.sv
module tagq_ptrs #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          flush,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [AW-1:0] wr_ptr_d, rd_ptr_d;
  logic [CW-1:0] count_d;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign pop_ok  = pop_req & ~empty & ~flush;
  assign push_ok = push_req & (~full | pop_ok) & ~flush;

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    count_d  = count;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (push_ok) wr_ptr_d = step(wr_ptr);
      if (pop_ok)  rd_ptr_d = step(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count_d = count + 1'b1;
        2'b01:   count_d = count - 1'b1;
        default: count_d = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= count_d;
    end
  end

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop_req && !flush) |=> $stable(count));

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0) && (wr_ptr == rd_ptr));

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req && !push_req && !flush) |=> (count == '0));

  // R10
  push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(count));
endmodule

// File: rtl/tagq_mem.sv
module tagq_mem #(
  parameter int DEPTH = 512,
  parameter int DW    = 16,
  parameter int TW    = 5,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [TW-1:0] wtag,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic [TW-1:0] rtag
);
  logic [DW-1:0] dat_q [DEPTH];
  logic [TW-1:0] tag_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      dat_q[waddr] <= wdata;
      tag_q[waddr] <= wtag;
    end
  end

  assign rdata = dat_q[raddr];
  assign rtag  = tag_q[raddr];
endmodule

// File: rtl/tagq_irq.sv
module tagq_irq #(
  parameter int CW        = 10,
  parameter int LEVEL_RST = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_level,
  input  logic          wr_enable,
  input  logic [CW-1:0] count,
  output logic          enable,
  output logic          irq
);
  logic [CW-1:0] level_q, level_d;
  logic          en_d;

  always_comb begin
    level_d = level_q;
    en_d    = enable;
    if (wr_en) begin
      level_d = wr_level;
      en_d    = wr_enable;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= CW'(LEVEL_RST);
      enable  <= 1'b0;
    end else begin
      level_q <= level_d;
      enable  <= en_d;
    end
  end

  assign irq = enable & (count > level_q);

  // R7
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> enable);

  // R6
  irq_off_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_enable) |=> !irq);
endmodule

// File: rtl/tagq_top.sv
module tagq_top
  import tagq_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int DW    = 16,
  parameter int TW    = 5,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int HB = DW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic [DW-1:0] push_sample,
  input  logic [TW-1:0] push_chan,
  input  logic          flush,
  output logic          full,
  input  logic          rd_word,
  input  logic          rd_lo,
  input  logic          rd_hi,
  input  logic          rd_stat,
  input  logic          wr_stat,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          irq
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rsel_e         rsel;
  logic          pop_req, push_ok, pop_ok, empty, enable;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic [DW-1:0] head_dat, rdata_d;
  logic [TW-1:0] head_tag, tag_vis;

  assign rsel    = pick_read(rd_word, rd_hi, rd_lo, rd_stat);
  assign pop_req = (rsel == RSEL_WORD) || (rsel == RSEL_HI);

  tagq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_int_n), .push_req(push_en), .pop_req(pop_req),
    .flush(flush), .push_ok(push_ok), .pop_ok(pop_ok), .wr_ptr(wr_ptr),
    .rd_ptr(rd_ptr), .count(count), .full(full), .empty(empty));

  tagq_mem #(.DEPTH(DEPTH), .DW(DW), .TW(TW)) u_mem (
    .clk(clk), .we(push_ok), .waddr(wr_ptr), .wdata(push_sample),
    .wtag(push_chan), .raddr(rd_ptr), .rdata(head_dat), .rtag(head_tag));

  tagq_irq #(.CW(CW), .LEVEL_RST(DEPTH / 2)) u_irq (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_stat),
    .wr_level(host_wdata[DW-1 -: CW]), .wr_enable(host_wdata[0]),
    .count(count), .enable(enable), .irq(irq));

  assign tag_vis = empty ? '0 : head_tag;

  always_comb begin
    rdata_d = host_rdata;
    unique case (rsel)
      RSEL_WORD: if (!empty) rdata_d = head_dat;
      RSEL_HI:   if (!empty) rdata_d = {{(DW-HB){1'b0}}, head_dat[DW-1:HB]};
      RSEL_LO:   if (!empty) rdata_d = {{(DW-HB){1'b0}}, head_dat[HB-1:0]};
      RSEL_STAT: rdata_d = {count, tag_vis, enable};
      default:   rdata_d = host_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) host_rdata <= '0;
    else            host_rdata <= rdata_d;
  end

  // R9
  empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (empty && (rd_word || rd_lo || rd_hi)) |=> $stable(host_rdata));

  // R4
  lo_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_lo && !rd_word && !rd_hi && !push_en && !flush) |=> $stable(count));
endmodule

// File: tb/tagq_top_tb.sv
module tagq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_en = 1'b0, flush = 1'b0;
  logic [15:0] push_sample = '0, host_wdata = '0;
  logic [4:0]  push_chan = '0;
  logic        rd_word = 1'b0, rd_lo = 1'b0, rd_hi = 1'b0, rd_stat = 1'b0, wr_stat = 1'b0;
  logic        full, irq;
  logic [15:0] host_rdata;

  int checks = 0, errors = 0;
  logic [20:0] q[$];
  logic [15:0] m_rd = '0;
  logic [9:0]  m_level = 10'd256;
  logic        m_en = 1'b0;

  always #5 clk = ~clk;

  tagq_top dut_i (.clk(clk), .rst_n(rst_n), .push_en(push_en),
    .push_sample(push_sample), .push_chan(push_chan), .flush(flush),
    .full(full), .rd_word(rd_word), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .rd_stat(rd_stat), .wr_stat(wr_stat), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq(irq));

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] stat_word(input int n, input logic [4:0] t,
                                            input logic e);
    return {n[9:0], (n > 0) ? t : 5'd0, e};
  endfunction

  function automatic logic exp_irq(input int n, input logic [9:0] lvl, input logic e);
    return e && (n > int'(lvl));
  endfunction

  // rk: 0 none, 1 word, 2 low byte, 3 high byte, 4 status
  task automatic cyc(input bit ps, input logic [15:0] d, input logic [4:0] t,
                     input int rk, input bit fl, input bit ws, input logic [15:0] wd);
    int  n;
    bit  pop;
    logic [20:0] h;
    n = q.size();
    h = (n > 0) ? q[0] : '0;
    push_en = ps; push_sample = d; push_chan = t; flush = fl;
    rd_word = (rk == 1); rd_lo = (rk == 2); rd_hi = (rk == 3); rd_stat = (rk == 4);
    wr_stat = ws; host_wdata = wd;
    if (rk == 1 && n > 0) m_rd = h[15:0];
    if (rk == 2 && n > 0) m_rd = {8'h00, h[7:0]};
    if (rk == 3 && n > 0) m_rd = {8'h00, h[15:8]};
    if (rk == 4) m_rd = stat_word(n, h[20:16], m_en);
    pop = (rk == 1 || rk == 3) && n > 0 && !fl;
    @(posedge clk);
    @(negedge clk);
    push_en = 0; flush = 0; rd_word = 0; rd_lo = 0; rd_hi = 0; rd_stat = 0; wr_stat = 0;
    if (fl) q.delete();
    else begin
      if (pop) void'(q.pop_front());
      if (ps && (n < 512 || pop)) q.push_back({t, d});
    end
    if (ws) begin m_level = wd[15:6]; m_en = wd[0]; end
    chk(host_rdata == m_rd, "R3/R4/R5/R9 rdata", host_rdata, m_rd);
    chk(full == (q.size() == 512), "R2 full", {15'd0, full}, {15'd0, q.size() == 512});
    chk(irq == exp_irq(q.size(), m_level, m_en), "R7 irq", {15'd0, irq},
        {15'd0, exp_irq(q.size(), m_level, m_en)});
  endtask

  task automatic stat_check(input string req);
    int n;
    n = q.size();
    cyc(0, 0, 0, 4, 0, 0, 0);
    chk(host_rdata[15:6] == 10'(n), req, {6'd0, host_rdata[15:6]}, 16'(n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd1, 16'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(host_rdata == 16'h0, "R1 rdata", host_rdata, 16'h0);
    chk(!full && !irq, "R1 flags", {14'd0, full, irq}, 16'h0);
    cyc(0, 0, 0, 4, 0, 0, 0);
    chk(host_rdata == 16'h0, "R1 R5 status at reset", host_rdata, 16'h0);

    // R1 default level 256: enable only, level bits 256
    cyc(0, 0, 0, 0, 0, 1, {10'd256, 5'd0, 1'b1});
    for (int i = 0; i < 256; i++) cyc(1, 16'(i * 7 + 3), 5'(i % 16), 0, 0, 0, 0);
    chk(irq == 1'b0, "R1 R7 irq at count=level", {15'd0, irq}, 16'h0);
    cyc(1, 16'hBEEF, 5'd9, 0, 0, 0, 0);
    chk(irq == 1'b1, "R7 irq above level", {15'd0, irq}, 16'h1);
    // R6 disable clears irq
    cyc(0, 0, 0, 0, 0, 1, {10'd256, 5'd0, 1'b0});
    chk(irq == 1'b0, "R6 disable", {15'd0, irq}, 16'h0);

    // R2 fill to full, push while full ignored
    while (q.size() < 512) cyc(1, 16'($urandom()), 5'($urandom() % 16), 0, 0, 0, 0);
    chk(full == 1'b1, "R2 full at 512", {15'd0, full}, 16'h1);
    cyc(1, 16'h1111, 5'd1, 0, 0, 0, 0);
    stat_check("R2 ignored push while full");
    // R10 push and pop at full
    cyc(1, 16'h2222, 5'd2, 1, 0, 0, 0);
    stat_check("R10 push+pop at full");
    // R4 low byte keeps, high byte pops
    cyc(0, 0, 0, 2, 0, 0, 0);
    stat_check("R4 low byte no pop");
    cyc(0, 0, 0, 3, 0, 0, 0);
    stat_check("R4 high byte pops");
    // R3 drain in order
    while (q.size() > 0) cyc(0, 0, 0, 1, 0, 0, 0);
    // R9 empty reads
    cyc(0, 0, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 2, 0, 0, 0);
    cyc(0, 0, 0, 3, 0, 0, 0);
    stat_check("R9 empty read count");
    // R10 push+pop on empty: push accepted only
    cyc(1, 16'hA5C3, 5'd7, 1, 0, 0, 0);
    stat_check("R10 push+pop on empty");
    // R8 flush with push and pop
    cyc(1, 16'h0F0F, 5'd3, 0, 0, 0, 0);
    cyc(1, 16'h7777, 5'd4, 1, 1, 0, 0);
    stat_check("R8 flush priority");
    // R5 tag visible
    cyc(1, 16'h1234, 5'd21, 0, 0, 0, 0);
    stat_check("R5 head tag");
    chk(host_rdata[5:1] == 5'd21, "R5 tag field", {11'd0, host_rdata[5:1]}, 16'd21);

    // random mix, R3 R4 R7 R8 R10
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom() % 100;
      cyc(($urandom() % 100) < 55, 16'($urandom()), 5'($urandom()),
          int'($urandom() % 5), (r == 0), (r > 96),
          {10'($urandom() % 64), 5'd0, 1'($urandom())});
    end
    stat_check("R10 random count");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule